// File: doc/BRIEF.md
# Ownership-Flagged Shared Mailbox Aperture

The block is a small shared mailbox of eight 32-bit words, reached by two agents through separate word-addressed read/write ports: a requester and a responder. The last word carries a control header, and its top bit is an ownership flag that tells both sides whose turn it is. The requester fills the payload words and then writes the header. That header write hands the mailbox to the responder as a side effect, without a separate handshake.

The responder reads the request and writes its reply header into the last word with the top bit cleared, which gives the mailbox back. While the requester owns the mailbox, its writes take effect. While the responder owns it, requester writes are dropped, and a header write attempt raises a sticky error flag.

A function-reset input forces every requester read to return all ones for as long as it is held. The contents of the mailbox are kept. Both ports read with one cycle of latency and flag returned data with a valid strobe.

Top module: `shmbox_aperture`

## Requirements
- R1: After rst_ni is asserted, every word (index 0 to 7) reads as 0x00000000, owner_rsp_o is 0 and req_err_o is 0.
- R2: A read issued on either port in cycle N presents its data with rvalid high in cycle N+1. rvalid is low in a cycle after no read. The data is the word's content before any write in cycle N.
- R3: A requester write to word 7 while the requester owns the mailbox stores data bits [30:0] into the header. From the next cycle, bit 31 of word 7 reads 1 (responder-owned), whatever value was written to bit 31.
- R4: While the requester owns the mailbox (bit 31 of word 7 = 0), requester writes to words 0 to 6 take effect. While the responder owns it, those writes are ignored and the words keep their contents. Ownership stays with the responder until the responder writes word 7.
- R5: A requester write to word 7 while the responder owns the mailbox changes nothing and sets req_err_o from the next cycle.
- R6: The responder may write any word at any time. A responder write to word 7 stores all 32 bits, so the ownership flag takes the written bit 31 (0 returns ownership to the requester).
- R7: When both ports write the same word in one cycle, the responder's data is kept and the requester's write is dropped. Writes to different words in one cycle both take effect.
- R8: A requester read issued while func_rst_i is high returns 0xFFFFFFFF. Responder reads are unaffected, and stored contents survive, so reads after release return the real data.
- R9: owner_rsp_o always equals bit 31 of word 7 as read through the ports.
- R10: Once set, req_err_o stays high until rst_ni is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, clears all state |
| func_rst_i | input | 1 | Function reset: requester reads return all ones while high |
| req_wr_i | input | 1 | Requester write strobe |
| req_rd_i | input | 1 | Requester read strobe |
| req_addr_i | input | 3 | Requester word index |
| req_wdata_i | input | 32 | Requester write data |
| req_rdata_o | output | 32 | Requester read data |
| req_rvalid_o | output | 1 | Requester read data valid |
| rsp_wr_i | input | 1 | Responder write strobe |
| rsp_rd_i | input | 1 | Responder read strobe |
| rsp_addr_i | input | 3 | Responder word index |
| rsp_wdata_i | input | 32 | Responder write data |
| rsp_rdata_o | output | 32 | Responder read data |
| rsp_rvalid_o | output | 1 | Responder read data valid |
| owner_rsp_o | output | 1 | Ownership flag, 1 = responder owns |
| req_err_o | output | 1 | Sticky error: requester header write while responder owns |

## Verification
The bench targets the handoff written with bit 31 clear. A design that copied the written bit would leave ownership with the requester and read back 0 in bit 31.

It also checks blocked requester writes to both payload and header. A design that gated only the header would corrupt payload under the responder, and one without the sticky flag would hide a lost request.

Same-cycle collisions on a payload word and on the header tell apart a design that lets the requester win. A read that coincides with a write shows whether read data passes through from the write.

Requester and responder reads are issued together under function reset. A design that masks the wrong port, or that clears storage, gives back the wrong data once the reset is released.

// File: rtl/shmbox_pkg.sv
package shmbox_pkg;
  localparam int unsigned DEF_WORD_W  = 32;
  localparam int unsigned DEF_N_WORDS = 8;
endpackage

// File: rtl/shmbox_store.sv
module shmbox_store #(
  parameter int unsigned WORD_W  = shmbox_pkg::DEF_WORD_W,
  parameter int unsigned N_WORDS = shmbox_pkg::DEF_N_WORDS,
  localparam int unsigned ADDR_W = $clog2(N_WORDS)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               owner_i,
  input  logic                               req_we_i,
  input  logic [ADDR_W-1:0]                  req_addr_i,
  input  logic [WORD_W-1:0]                  req_wdata_i,
  input  logic                               rsp_we_i,
  input  logic [ADDR_W-1:0]                  rsp_addr_i,
  input  logic [WORD_W-1:0]                  rsp_wdata_i,
  output logic [N_WORDS-2:0][WORD_W-1:0]     words_o
);
  for (genvar g = 0; g < N_WORDS - 1; g++) begin : g_word
    logic rsp_hit, req_hit;
    assign rsp_hit = rsp_we_i && (rsp_addr_i == ADDR_W'(g));
    assign req_hit = req_we_i && (req_addr_i == ADDR_W'(g)) && !owner_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      words_o[g] <= '0;
      else if (rsp_hit) words_o[g] <= rsp_wdata_i;
      else if (req_hit) words_o[g] <= req_wdata_i;
    end
  end
endmodule

// File: rtl/shmbox_owner.sv
module shmbox_owner #(
  parameter int unsigned WORD_W = shmbox_pkg::DEF_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_we_last_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  input  logic              rsp_we_last_i,
  input  logic [WORD_W-1:0] rsp_wdata_i,
  output logic [WORD_W-1:0] hdr_word_o,
  output logic              owner_o,
  output logic              err_o
);
  localparam int unsigned OWN_BIT = WORD_W - 1;

  logic [OWN_BIT-1:0] hdr_q;
  logic               owner_q;
  logic               err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q   <= '0;
      owner_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (rsp_we_last_i) begin
        hdr_q   <= rsp_wdata_i[OWN_BIT-1:0];
        owner_q <= rsp_wdata_i[OWN_BIT];
      end else if (req_we_last_i && !owner_q) begin
        // header write hands the mailbox over
        hdr_q   <= req_wdata_i[OWN_BIT-1:0];
        owner_q <= 1'b1;
      end
      if (req_we_last_i && owner_q) err_q <= 1'b1;
    end
  end

  assign hdr_word_o = {owner_q, hdr_q};
  assign owner_o    = owner_q;
  assign err_o      = err_q;
endmodule

// File: rtl/shmbox_rdport.sv
module shmbox_rdport #(
  parameter int unsigned WORD_W  = shmbox_pkg::DEF_WORD_W,
  parameter int unsigned N_WORDS = shmbox_pkg::DEF_N_WORDS,
  localparam int unsigned ADDR_W = $clog2(N_WORDS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rd_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           ones_i,
  input  logic [N_WORDS-1:0][WORD_W-1:0] window_i,
  output logic [WORD_W-1:0]              rdata_o,
  output logic                           rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= ones_i ? '1 : window_i[addr_i];
    end
  end
endmodule

// File: rtl/shmbox_aperture.sv
module shmbox_aperture #(
  parameter int unsigned WORD_W  = shmbox_pkg::DEF_WORD_W,
  parameter int unsigned N_WORDS = shmbox_pkg::DEF_N_WORDS,
  localparam int unsigned ADDR_W = $clog2(N_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              func_rst_i,
  input  logic              req_wr_i,
  input  logic              req_rd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic [WORD_W-1:0] req_rdata_o,
  output logic              req_rvalid_o,
  input  logic              rsp_wr_i,
  input  logic              rsp_rd_i,
  input  logic [ADDR_W-1:0] rsp_addr_i,
  input  logic [WORD_W-1:0] rsp_wdata_i,
  output logic [WORD_W-1:0] rsp_rdata_o,
  output logic              rsp_rvalid_o,
  output logic              owner_rsp_o,
  output logic              req_err_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_WORDS - 1);

  logic [N_WORDS-2:0][WORD_W-1:0] payload;
  logic [WORD_W-1:0]              hdr_word;
  logic [N_WORDS-1:0][WORD_W-1:0] window;
  logic                           owner;
  logic                           req_we_last, rsp_we_last;

  assign req_we_last = req_wr_i && (req_addr_i == LAST);
  assign rsp_we_last = rsp_wr_i && (rsp_addr_i == LAST);
  assign window      = {hdr_word, payload};

  shmbox_store #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .owner_i(owner),
    .req_we_i(req_wr_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_we_i(rsp_wr_i), .rsp_addr_i(rsp_addr_i), .rsp_wdata_i(rsp_wdata_i),
    .words_o(payload)
  );

  shmbox_owner #(.WORD_W(WORD_W)) u_owner (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_we_last_i(req_we_last), .req_wdata_i(req_wdata_i),
    .rsp_we_last_i(rsp_we_last), .rsp_wdata_i(rsp_wdata_i),
    .hdr_word_o(hdr_word), .owner_o(owner), .err_o(req_err_o)
  );

  shmbox_rdport #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_rd_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(req_rd_i), .addr_i(req_addr_i),
    .ones_i(func_rst_i), .window_i(window),
    .rdata_o(req_rdata_o), .rvalid_o(req_rvalid_o)
  );

  shmbox_rdport #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_rd_rsp (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rsp_rd_i), .addr_i(rsp_addr_i),
    .ones_i(1'b0), .window_i(window),
    .rdata_o(rsp_rdata_o), .rvalid_o(rsp_rvalid_o)
  );

  assign owner_rsp_o = owner;
endmodule

// File: rtl/shmbox_checker.sv
module shmbox_checker #(
  parameter int unsigned WORD_W  = shmbox_pkg::DEF_WORD_W,
  parameter int unsigned N_WORDS = shmbox_pkg::DEF_N_WORDS,
  localparam int unsigned ADDR_W = $clog2(N_WORDS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              func_rst_i,
  input logic              req_wr_i,
  input logic              req_rd_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [WORD_W-1:0] req_rdata_o,
  input logic              req_rvalid_o,
  input logic              rsp_wr_i,
  input logic              rsp_rd_i,
  input logic [ADDR_W-1:0] rsp_addr_i,
  input logic [WORD_W-1:0] rsp_wdata_i,
  input logic              rsp_rvalid_o,
  input logic              owner_rsp_o,
  input logic              req_err_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_WORDS - 1);

  a_r2_req_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_rd_i |=> req_rvalid_o);
  a_r2_req_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_rd_i |=> !req_rvalid_o);
  a_r2_rsp_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_rd_i |=> rsp_rvalid_o);
  a_r3_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_wr_i && req_addr_i == LAST && !owner_rsp_o && !(rsp_wr_i && rsp_addr_i == LAST))
    |=> owner_rsp_o);
  a_r4_owner_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_rsp_o && !(rsp_wr_i && rsp_addr_i == LAST)) |=> owner_rsp_o);
  a_r5_busy_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_wr_i && req_addr_i == LAST && owner_rsp_o) |=> req_err_o);
  a_r6_rsp_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_wr_i && rsp_addr_i == LAST) |=> owner_rsp_o == $past(rsp_wdata_i[WORD_W-1]));
  a_r8_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_rd_i && func_rst_i) |=> req_rdata_o == '1);
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_err_o |=> req_err_o);
endmodule

bind shmbox_aperture shmbox_checker #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .func_rst_i(func_rst_i),
  .req_wr_i(req_wr_i), .req_rd_i(req_rd_i), .req_addr_i(req_addr_i),
  .req_rdata_o(req_rdata_o), .req_rvalid_o(req_rvalid_o),
  .rsp_wr_i(rsp_wr_i), .rsp_rd_i(rsp_rd_i), .rsp_addr_i(rsp_addr_i),
  .rsp_wdata_i(rsp_wdata_i), .rsp_rvalid_o(rsp_rvalid_o),
  .owner_rsp_o(owner_rsp_o), .req_err_o(req_err_o)
);

// File: tb/shmbox_aperture_bench.sv
module shmbox_aperture_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni, func_rst_i;
  logic        req_wr_i, req_rd_i, rsp_wr_i, rsp_rd_i;
  logic [2:0]  req_addr_i, rsp_addr_i;
  logic [31:0] req_wdata_i, rsp_wdata_i, req_rdata_o, rsp_rdata_o;
  logic        req_rvalid_o, rsp_rvalid_o, owner_rsp_o, req_err_o;
  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  shmbox_aperture u_shmbox_aperture (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle on both ports; returns at the negedge after the commit edge
  task automatic step(input logic qw, input logic qr, input logic [2:0] qa, input logic [31:0] qd,
                      input logic pw, input logic pr, input logic [2:0] pa, input logic [31:0] pd);
    req_wr_i = qw; req_rd_i = qr; req_addr_i = qa; req_wdata_i = qd;
    rsp_wr_i = pw; rsp_rd_i = pr; rsp_addr_i = pa; rsp_wdata_i = pd;
    @(posedge clk_i);
    @(negedge clk_i);
    req_wr_i = 0; req_rd_i = 0; rsp_wr_i = 0; rsp_rd_i = 0;
  endtask

  task automatic req_write(input logic [2:0] a, input logic [31:0] d);
    step(1, 0, a, d, 0, 0, 0, 0);
  endtask
  task automatic rsp_write(input logic [2:0] a, input logic [31:0] d);
    step(0, 0, 0, 0, 1, 0, a, d);
  endtask
  task automatic req_read_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    step(0, 1, a, 0, 0, 0, 0, 0);
    chk({tag, " rvalid"}, {31'b0, req_rvalid_o}, 32'd1);
    chk(tag, req_rdata_o, exp);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) req_read_chk("R1 word after reset", 3'(i), 32'h0);
    chk("R1 owner after reset", {31'b0, owner_rsp_o}, 32'd0);
    chk("R1 err after reset", {31'b0, req_err_o}, 32'd0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 rvalid idle", {31'b0, req_rvalid_o}, 32'd0);
  endtask

  task automatic t_payload;
    for (int i = 0; i < 7; i++) req_write(3'(i), 32'hA000_0000 + i);
    for (int i = 0; i < 7; i++) req_read_chk("R4 payload write owned", 3'(i), 32'hA000_0000 + i);
  endtask

  task automatic t_read_during_write;
    step(0, 1, 3'd0, 0, 1, 0, 3'd0, 32'h5555_0000);
    chk("R2 old data on same-cycle write", req_rdata_o, 32'hA000_0000);
    req_read_chk("R6 responder payload write", 3'd0, 32'h5555_0000);
  endtask

  task automatic t_handoff;
    req_write(3'd7, 32'h0100_0009);
    chk("R9 owner after handoff", {31'b0, owner_rsp_o}, 32'd1);
    req_read_chk("R3 header with owner set", 3'd7, 32'h8100_0009);
  endtask

  task automatic t_blocked;
    req_write(3'd2, 32'hDEAD_BEEF);
    req_read_chk("R4 payload write ignored", 3'd2, 32'hA000_0002);
    chk("R5 no err on payload", {31'b0, req_err_o}, 32'd0);
    req_write(3'd7, 32'h0000_0002);
    chk("R5 err on busy header", {31'b0, req_err_o}, 32'd1);
    req_read_chk("R5 header unchanged", 3'd7, 32'h8100_0009);
  endtask

  task automatic t_reply;
    rsp_write(3'd7, 32'h8000_0081);
    chk("R6 owner kept by bit31=1", {31'b0, owner_rsp_o}, 32'd1);
    rsp_write(3'd7, 32'h0000_0181);
    chk("R6 owner returned", {31'b0, owner_rsp_o}, 32'd0);
    req_read_chk("R9 reply header", 3'd7, 32'h0000_0181);
    chk("R10 err still set", {31'b0, req_err_o}, 32'd1);
  endtask

  task automatic t_collision;
    step(1, 0, 3'd1, 32'h1111_1111, 1, 0, 3'd1, 32'h2222_2222);
    req_read_chk("R7 same word responder wins", 3'd1, 32'h2222_2222);
    step(1, 0, 3'd3, 32'h3333_3333, 1, 0, 3'd4, 32'h4444_4444);
    req_read_chk("R7 split write req", 3'd3, 32'h3333_3333);
    req_read_chk("R7 split write rsp", 3'd4, 32'h4444_4444);
    step(1, 0, 3'd7, 32'h0000_0001, 1, 0, 3'd7, 32'h0000_0042);
    chk("R7 header clash owner", {31'b0, owner_rsp_o}, 32'd0);
    req_read_chk("R7 header clash data", 3'd7, 32'h0000_0042);
  endtask

  task automatic t_func_reset;
    func_rst_i = 1'b1;
    step(0, 1, 3'd1, 0, 0, 1, 3'd1, 0);
    chk("R8 requester reads ones", req_rdata_o, 32'hFFFF_FFFF);
    chk("R8 responder unaffected", rsp_rdata_o, 32'h2222_2222);
    func_rst_i = 1'b0;
    req_read_chk("R8 contents kept", 3'd1, 32'h2222_2222);
  endtask

  task automatic t_por;
    chk("R10 err before reset", {31'b0, req_err_o}, 32'd1);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 err cleared", {31'b0, req_err_o}, 32'd0);
    req_read_chk("R1 payload cleared", 3'd1, 32'h0);
  endtask

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 0; func_rst_i = 0;
    req_wr_i = 0; req_rd_i = 0; req_addr_i = 0; req_wdata_i = 0;
    rsp_wr_i = 0; rsp_rd_i = 0; rsp_addr_i = 0; rsp_wdata_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_payload();
    t_read_during_write();
    t_handoff();
    t_blocked();
    t_reply();
    t_collision();
    t_func_reset();
    t_por();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule